// File: doc/BRIEF.md
# Quadratic Permutation Address Generator

This block produces the address sequence of a quadratic permutation interleaver. The permutation is P(i) = (f1*i + f2*i^2) mod N. It emits one address per clock and uses neither a multiplier nor a divider. A turbo decoder, or any block that reads a frame memory in permuted order, pulses a start input with the block length and the two polynomial coefficients. From the next cycle on, the generator streams the index i and the address P(i), from i = 0 up to i = N-1, and flags the final pair.

Each address comes from the one before it, so no address table is stored. The running increment P(i+1) - P(i) is held in a second register, and that register grows by 2*f2 on every step. Every sum of two values below N is brought back into range by one conditional subtraction of N. The start pulse loads the recursion seed: the address is 0 and the increment is (f1 + f2) mod N. A new start pulse during a sequence abandons it and begins again with the new parameters.

Top module: `qpp_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, outValid and outLast are 0, and outIdx and outAddr are 0 until the first start pulse is sampled.
- R2: On the clock edge that samples startPulse high, the block latches blkLen, coefA and coefB. From the cycle after that edge, outValid is 1, outIdx is 0 and outAddr is 0.
- R3: While outValid is 1, outAddr equals (coefA*outIdx + coefB*outIdx^2) mod blkLen, using the latched parameters. Each following cycle that is still part of the same sequence shows outIdx increased by exactly one.
- R4: While a sequence runs, outAddr and the internal increment both stay strictly below the latched blkLen. Each is reduced by at most one subtraction of blkLen.
- R5: outLast is 1 exactly in the cycle where outValid is 1 and outIdx equals blkLen-1. In the following cycle outValid is 0 unless a new start pulse was sampled on that edge.
- R6: Block lengths from 40 to 6144 are accepted. For a valid coefficient pair, the N addresses of one sequence are all distinct and each lies in 0..N-1.
- R7: A start pulse sampled during a running sequence restarts at index 0 and address 0 with the newly presented parameters. The old sequence produces no further addresses.
- R8: Changes on blkLen, coefA or coefB while no start pulse is present have no effect on the running sequence. The coefficients must be presented already reduced below blkLen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | One-cycle request to begin (or restart) a sequence |
| blkLen | input | 14 | Block length N, 40..6144, sampled with startPulse |
| coefA | input | 14 | Linear coefficient f1, below N, sampled with startPulse |
| coefB | input | 14 | Quadratic coefficient f2, below N, sampled with startPulse |
| outIdx | output | 14 | Index i of the current address |
| outAddr | output | 14 | Permuted address P(i) |
| outValid | output | 1 | outIdx/outAddr hold a live pair |
| outLast | output | 1 | Current pair is the final one (i = N-1) |

## Verification
On every cycle the assertions check the following: the address and increment registers stay below the latched length, the index advances by one per step, the sequence stops after the final index, a start clears the index and address, and the latched parameters do not move while stepping. These checks cannot show that the recursion yields the correct polynomial values. The bench shows this by comparing each address against a direct evaluation of the polynomial. The bench scenarios alone also cover the restart in mid-sequence, the start on the final cycle, parameter changes that must be ignored, and the fact that a full 6144-entry sequence is a true permutation.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
  localparam int DEF_LEN_W = 14;

  typedef struct packed {
    logic load;
    logic step;
  } qppStrobe_t;
endpackage

// File: rtl/qpp_ctrl.sv
module qpp_ctrl
  import qpp_pkg::*;
#(
  parameter int LEN_W   = DEF_LEN_W,
  parameter int MIN_LEN = 40,
  parameter int MAX_LEN = 6144
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startPulse,
  input  logic [LEN_W-1:0] blkLen,
  output qppStrobe_t       strobe,
  output logic [LEN_W-1:0] idx,
  output logic             running,
  output logic             isLast
);
  logic [LEN_W-1:0] lastIdx;

  assign isLast      = running && (idx == lastIdx);
  assign strobe.load = startPulse;
  assign strobe.step = running && !isLast && !startPulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      idx     <= '0;
      lastIdx <= '0;
    end else if (startPulse) begin
      running <= 1'b1;
      idx     <= '0;
      lastIdx <= blkLen - 1'b1;
    end else if (running) begin
      if (isLast) running <= 1'b0;
      else        idx     <= idx + 1'b1;
    end
  end

  AST_START_CLEARS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> (running && idx == '0));                                   // R2
  AST_IDX_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !isLast && !startPulse) |=> (running && idx == $past(idx) + 1'b1)); // R3
  AST_LAST_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (isLast && !startPulse) |=> !running);                                     // R5
  AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |-> (blkLen >= LEN_W'(MIN_LEN) && blkLen <= LEN_W'(MAX_LEN)));  // R6
endmodule

// File: rtl/qpp_datapath.sv
module qpp_datapath
  import qpp_pkg::*;
#(
  parameter int LEN_W = DEF_LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qppStrobe_t       strobe,
  input  logic [LEN_W-1:0] blkLen,
  input  logic [LEN_W-1:0] coefA,
  input  logic [LEN_W-1:0] coefB,
  output logic [LEN_W-1:0] addr
);
  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] incReg;
  logic [LEN_W-1:0] twoB;

  // sum of two residues, folded back with one conditional subtraction
  function automatic logic [LEN_W-1:0] modAdd(input logic [LEN_W-1:0] a,
                                               input logic [LEN_W-1:0] b,
                                               input logic [LEN_W-1:0] n);
    logic [LEN_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, n}) s = s - {1'b0, n};
    return s[LEN_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lenReg <= '0;
      addr   <= '0;
      incReg <= '0;
      twoB   <= '0;
    end else if (strobe.load) begin
      lenReg <= blkLen;
      addr   <= '0;
      incReg <= modAdd(coefA, coefB, blkLen);
      twoB   <= modAdd(coefB, coefB, blkLen);
    end else if (strobe.step) begin
      addr   <= modAdd(addr, incReg, lenReg);
      incReg <= modAdd(incReg, twoB, lenReg);
    end
  end

  AST_ADDR_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.step |-> (addr < lenReg && incReg < lenReg && twoB < lenReg));    // R4
  AST_LOAD_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> (addr == '0));                                          // R2
  AST_PARAMS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.step && !$past(strobe.load)) |-> ($stable(lenReg) && $stable(twoB))); // R8
endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen
  import qpp_pkg::*;
#(
  parameter int LEN_W   = DEF_LEN_W,
  parameter int MIN_LEN = 40,
  parameter int MAX_LEN = 6144
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startPulse,
  input  logic [LEN_W-1:0] blkLen,
  input  logic [LEN_W-1:0] coefA,
  input  logic [LEN_W-1:0] coefB,
  output logic [LEN_W-1:0] outIdx,
  output logic [LEN_W-1:0] outAddr,
  output logic             outValid,
  output logic             outLast
);
  qppStrobe_t strobe;

  qpp_ctrl #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startPulse (startPulse),
    .blkLen     (blkLen),
    .strobe     (strobe),
    .idx        (outIdx),
    .running    (outValid),
    .isLast     (outLast)
  );

  qpp_datapath #(.LEN_W(LEN_W)) uData (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .blkLen (blkLen),
    .coefA  (coefA),
    .coefB  (coefB),
    .addr   (outAddr)
  );
endmodule

// File: tb/qpp_addr_gen_test.sv
module qpp_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startPulse = 1'b0;
  logic [13:0] blkLen = '0;
  logic [13:0] coefA = '0;
  logic [13:0] coefB = '0;
  logic [13:0] outIdx, outAddr;
  logic        outValid, outLast;

  int checks = 0;
  int errors = 0;
  string scen = "R1";

  // reference model state
  bit      expValid = 0;
  longint  expIdx = 0, expN = 0, expA = 0, expB = 0;
  bit      seen [0:6143];

  always #2.5 clk = ~clk;

  qpp_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .blkLen(blkLen),
    .coefA(coefA), .coefB(coefB), .outIdx(outIdx), .outAddr(outAddr),
    .outValid(outValid), .outLast(outLast)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", tag, scen, act, exp, $time);
    end
  endtask

  // behavioural model, advances on every edge
  always @(posedge clk) begin
    if (rst_n) begin
      if (startPulse) begin
        expValid = 1; expIdx = 0;
        expN = blkLen; expA = coefA; expB = coefB;
        for (int k = 0; k < 6144; k++) seen[k] = 0;
      end else if (expValid) begin
        if (expIdx == expN - 1) expValid = 0;
        else expIdx++;
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(outValid == expValid, "R2 R5 valid", outValid, expValid);
      check(outLast == (expValid && expIdx == expN - 1), "R5 last", outLast,
            (expValid && expIdx == expN - 1));
      if (expValid) begin
        longint ref_addr;
        ref_addr = (expA * expIdx + expB * expIdx * expIdx) % expN;
        check(outIdx == expIdx, "R3 idx", outIdx, expIdx);
        check(outAddr == ref_addr, "R3 R8 addr", outAddr, ref_addr);
        check(outAddr < expN, "R4 range", outAddr, expN - 1);
        if (outAddr < 6144) begin
          check(!seen[outAddr], "R6 distinct", outAddr, -1);
          seen[outAddr] = 1;
        end
      end
    end
  end

  task automatic launch(input int n, input int a, input int b);
    @(negedge clk);
    startPulse = 1'b1; blkLen = 14'(n); coefA = 14'(a); coefB = 14'(b);
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid && !outLast && outIdx == 0 && outAddr == 0, "R1 reset", outValid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!outValid && !outLast && outIdx == 0 && outAddr == 0, "R1 idle", outValid, 0);

    scen = "R3 N40";
    launch(40, 3, 10);
    repeat (42) @(negedge clk);

    scen = "R3 N104";
    launch(104, 7, 26);
    repeat (106) @(negedge clk);

    scen = "R8 N1024";
    launch(1024, 31, 64);
    repeat (5) @(negedge clk);
    blkLen = 14'd500; coefA = 14'd13; coefB = 14'd999;
    repeat (1022) @(negedge clk);

    scen = "R7 restart";
    launch(40, 3, 10);
    repeat (15) @(negedge clk);
    launch(6144, 263, 480);
    check(outValid && outIdx == 0 && outAddr == 0, "R7 restart", outIdx, 0);
    scen = "R6 N6144";
    repeat (6146) @(negedge clk);

    scen = "R5 back-to-back";
    launch(40, 3, 10);
    while (!outLast) @(negedge clk);
    startPulse = 1'b1; blkLen = 14'd48; coefA = 14'd7; coefB = 14'd12;
    @(negedge clk);
    startPulse = 1'b0;
    check(outValid && outIdx == 0 && outAddr == 0, "R5 restart on last", outIdx, 0);
    repeat (50) @(negedge clk);
    check(!outValid && !outLast, "R5 idle after end", outValid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule